// File: doc/BRIEF.md
# Display Mode Command Decoder

This block sits behind two byte-wide command ports of a display controller and turns each written command byte into a change of one configuration flag. On the mode port, each command byte picks one flag and its least significant bit carries the new value. The flags cover the 16-color analog mode, the extended graphics engine, the 256-color mode, the display type (CRT or flat panel), the video memory boundary and two graphics clock select bits. A raster port works the same way and holds four text and raster options.

Some of the mode flags are protected. The extended graphics enable and the 256-color enable move only after an unlock command has opened a latch. Each capability is also gated by a strap input that tells whether the chip variant supports it. The faster graphics clock is active only while both clock bits are set. A single-cycle pulse marks every change of that derived clock flag, so the clock generator can resynchronise. Any byte that is not a recognised command leaves all state as it is.

Top module: `disp_mode_cmd_dec`

## Requirements
- R1: After reset every flag, the unlock latch and both clock bits are 0, and so are all outputs.
- R2: Mode command 0x00 clears `color16_en` and 0x01 sets it; the set is ignored while `cap_16c` is 0.
- R3: Mode command 0x07 opens the unlock latch and 0x06 closes it; 0x04 clears and 0x05 sets `extgfx_en` only while the latch is open, and the set also needs `cap_ext`.
- R4: Mode commands 0x20 (clear) and 0x21 (set) change `color256_en` only while the latch is open and `cap_ext` is 1; the set also needs `cap_256`.
- R5: Mode commands 0x40/0x41 write `panel_sel` (1 = flat panel) and 0x68/0x69 write `vram_wide` (1 = 256 KB boundary), each from the command LSB.
- R6: Mode commands 0x82/0x83 write `clk_bit1` and 0x84/0x85 write `clk_bit2` from the LSB; `fast_clk` is 1 exactly when both bits are 1.
- R7: `fast_clk_chg` is high for exactly the one cycle in which `fast_clk` differs from its value in the previous cycle, and is low otherwise.
- R8: `analog_pal` is 1 exactly when `color16_en` or `color256_en` is 1.
- R9: On the raster port, 0x00/0x01 write `attr4_gfx`, 0x04/0x05 write `col40`, 0x08/0x09 write `hide_odd` and 0x0E/0x0F write `disp_en`, each from the LSB.
- R10: Any byte that R2 to R6 do not list on the mode port, or that R9 does not list on the raster port (0x0A and 0x0B on both ports included), changes no state.
- R11: A command updates its flag on the clock edge at which its valid strobe is sampled high, and the new value is visible at the outputs from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_vld | input | 1 | Mode port command strobe |
| mode_cmd | input | CMD_W | Mode port command byte |
| ras_vld | input | 1 | Raster port command strobe |
| ras_cmd | input | CMD_W | Raster port command byte |
| cap_16c | input | 1 | Strap: 16-color mode supported |
| cap_ext | input | 1 | Strap: extended graphics supported |
| cap_256 | input | 1 | Strap: 256-color mode supported |
| color16_en | output | 1 | 16-color analog mode enable |
| extgfx_en | output | 1 | Extended graphics enable |
| color256_en | output | 1 | 256-color mode enable |
| panel_sel | output | 1 | 1 = flat panel, 0 = CRT |
| vram_wide | output | 1 | 1 = 256 KB boundary, 0 = 128 KB |
| clk_bit1 | output | 1 | Graphics clock select bit 1 |
| clk_bit2 | output | 1 | Graphics clock select bit 2 |
| fast_clk | output | 1 | Faster graphics clock active |
| fast_clk_chg | output | 1 | One-cycle pulse on change of fast_clk |
| analog_pal | output | 1 | Analog palette in use |
| attr4_gfx | output | 1 | Attribute bit 4 selects simple graphic |
| col40 | output | 1 | 40-column text mode |
| hide_odd | output | 1 | Hide odd rasters in 200-line mode |
| disp_en | output | 1 | Display enable |

## Verification
The bench builds the block with the default CMD_W of 8. At that width the full command space has only 256 values, so every unlisted byte on both ports can be swept while the flags hold a mix of ones and zeros, and any stray decode shows up as a changed flag. The strap inputs are not parameters but ports, so the bench changes them between commands. This reaches the gated paths with each strap at 0 and at 1, with the latch both open and closed.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

  // Mode port command pairs (LSB carries the value)
  localparam logic [7:0] MC_C16   = 8'h00;
  localparam logic [7:0] MC_EXT   = 8'h04;
  localparam logic [7:0] MC_UNL   = 8'h06;
  localparam logic [7:0] MC_C256  = 8'h20;
  localparam logic [7:0] MC_PANEL = 8'h40;
  localparam logic [7:0] MC_WIDE  = 8'h68;
  localparam logic [7:0] MC_CLK1  = 8'h82;
  localparam logic [7:0] MC_CLK2  = 8'h84;

  // Raster port command pairs
  localparam logic [7:0] RC_ATTR  = 8'h00;
  localparam logic [7:0] RC_COL40 = 8'h04;
  localparam logic [7:0] RC_HIDE  = 8'h08;
  localparam logic [7:0] RC_DISP  = 8'h0E;

  function automatic logic fast_of(input logic b1, input logic b2);
    return b1 & b2;
  endfunction

  function automatic logic analog_of(input logic c16, input logic c256);
    return c16 | c256;
  endfunction

  // A set request passes only if its gate is open; a clear always passes.
  function automatic logic gated_write(input logic val, input logic set_ok);
    return ~val | set_ok;
  endfunction

endpackage

// File: rtl/disp_mode_dec.sv
module disp_mode_dec
  import disp_cmd_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [CMD_W-1:0] cmd,
  input  logic             cap_16c,
  input  logic             cap_ext,
  input  logic             cap_256,
  output logic             c16_o,
  output logic             ext_o,
  output logic             c256_o,
  output logic             panel_o,
  output logic             wide_o,
  output logic             b1_o,
  output logic             b2_o
);

  function automatic logic pair_hit(input logic [CMD_W-1:0] c, input logic [7:0] code);
    logic [CMD_W-1:0] w;
    w = CMD_W'(code);
    return (c >> 1) == (w >> 1);
  endfunction

  logic lsb;
  assign lsb = cmd[0];

  // Named decode events
  logic hit_c16, hit_unl, hit_ext, hit_c256, hit_panel, hit_wide, hit_b1, hit_b2;
  assign hit_c16   = vld & pair_hit(cmd, MC_C16);
  assign hit_unl   = vld & pair_hit(cmd, MC_UNL);
  assign hit_ext   = vld & pair_hit(cmd, MC_EXT);
  assign hit_c256  = vld & pair_hit(cmd, MC_C256);
  assign hit_panel = vld & pair_hit(cmd, MC_PANEL);
  assign hit_wide  = vld & pair_hit(cmd, MC_WIDE);
  assign hit_b1    = vld & pair_hit(cmd, MC_CLK1);
  assign hit_b2    = vld & pair_hit(cmd, MC_CLK2);

  logic unl_q;
  logic wr_c16, wr_ext, wr_c256;
  assign wr_c16  = hit_c16  & gated_write(lsb, cap_16c);
  assign wr_ext  = hit_ext  & unl_q & gated_write(lsb, cap_ext);
  assign wr_c256 = hit_c256 & unl_q & cap_ext & gated_write(lsb, cap_256);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unl_q   <= 1'b0;
      c16_o   <= 1'b0;
      ext_o   <= 1'b0;
      c256_o  <= 1'b0;
      panel_o <= 1'b0;
      wide_o  <= 1'b0;
      b1_o    <= 1'b0;
      b2_o    <= 1'b0;
    end else begin
      if (hit_unl)   unl_q   <= lsb;
      if (wr_c16)    c16_o   <= lsb;
      if (wr_ext)    ext_o   <= lsb;
      if (wr_c256)   c256_o  <= lsb;
      if (hit_panel) panel_o <= lsb;
      if (hit_wide)  wide_o  <= lsb;
      if (hit_b1)    b1_o    <= lsb;
      if (hit_b2)    b2_o    <= lsb;
    end
  end

  p_c16_strap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_16c |=> !$rose(c16_o));

  p_ext_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !unl_q |=> $stable(ext_o));

  p_c256_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q || !cap_ext) |=> $stable(c256_o));

  p_mode_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable({unl_q, c16_o, ext_o, c256_o, panel_o, wide_o, b1_o, b2_o}));

endmodule

// File: rtl/disp_raster_dec.sv
module disp_raster_dec
  import disp_cmd_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [CMD_W-1:0] cmd,
  output logic             attr_o,
  output logic             col40_o,
  output logic             hide_o,
  output logic             disp_o
);

  localparam int NFLAG = 4;
  localparam logic [7:0] CODES [NFLAG] = '{RC_ATTR, RC_COL40, RC_HIDE, RC_DISP};

  logic [NFLAG-1:0] hit;
  logic [NFLAG-1:0] flag_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic [CMD_W-1:0] code_w;
    assign code_w = CMD_W'(CODES[g]);
    assign hit[g] = vld & ((cmd >> 1) == (code_w >> 1));
    always_ff @(posedge clk) begin
      if (!rst_n)      flag_q[g] <= 1'b0;
      else if (hit[g]) flag_q[g] <= cmd[0];
    end
  end

  assign attr_o  = flag_q[0];
  assign col40_o = flag_q[1];
  assign hide_o  = flag_q[2];
  assign disp_o  = flag_q[3];

  p_ras_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  p_ras_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(flag_q));

endmodule

// File: rtl/disp_clk_combine.sv
module disp_clk_combine
  import disp_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic b1,
  input  logic b2,
  output logic fast_o,
  output logic chg_o
);

  logic fast_prev_q;

  assign fast_o = fast_of(b1, b2);

  always_ff @(posedge clk) begin
    if (!rst_n) fast_prev_q <= 1'b0;
    else        fast_prev_q <= fast_o;
  end

  assign chg_o = fast_o ^ fast_prev_q;

  p_fast_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> !$stable(fast_o));

  p_fast_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(fast_o) |-> !chg_o);

endmodule

// File: rtl/disp_mode_cmd_dec.sv
module disp_mode_cmd_dec
  import disp_cmd_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_vld,
  input  logic [CMD_W-1:0] mode_cmd,
  input  logic             ras_vld,
  input  logic [CMD_W-1:0] ras_cmd,
  input  logic             cap_16c,
  input  logic             cap_ext,
  input  logic             cap_256,
  output logic             color16_en,
  output logic             extgfx_en,
  output logic             color256_en,
  output logic             panel_sel,
  output logic             vram_wide,
  output logic             clk_bit1,
  output logic             clk_bit2,
  output logic             fast_clk,
  output logic             fast_clk_chg,
  output logic             analog_pal,
  output logic             attr4_gfx,
  output logic             col40,
  output logic             hide_odd,
  output logic             disp_en
);

  disp_mode_dec #(.CMD_W(CMD_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (mode_vld),
    .cmd     (mode_cmd),
    .cap_16c (cap_16c),
    .cap_ext (cap_ext),
    .cap_256 (cap_256),
    .c16_o   (color16_en),
    .ext_o   (extgfx_en),
    .c256_o  (color256_en),
    .panel_o (panel_sel),
    .wide_o  (vram_wide),
    .b1_o    (clk_bit1),
    .b2_o    (clk_bit2)
  );

  disp_raster_dec #(.CMD_W(CMD_W)) u_ras (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (ras_vld),
    .cmd     (ras_cmd),
    .attr_o  (attr4_gfx),
    .col40_o (col40),
    .hide_o  (hide_odd),
    .disp_o  (disp_en)
  );

  disp_clk_combine u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .b1     (clk_bit1),
    .b2     (clk_bit2),
    .fast_o (fast_clk),
    .chg_o  (fast_clk_chg)
  );

  assign analog_pal = analog_of(color16_en, color256_en);

  p_fast_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk |-> (clk_bit1 && clk_bit2));

  p_analog_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    analog_pal |-> (color16_en || color256_en));

  p_c256_analog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    color256_en |-> analog_pal);

endmodule

// File: tb/disp_mode_cmd_dec_tb_top.sv
`timescale 1ns/1ps
module disp_mode_cmd_dec_tb_top;

  localparam int CMD_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_vld = 1'b0, ras_vld = 1'b0;
  logic [CMD_W-1:0] mode_cmd = '0, ras_cmd = '0;
  logic cap_16c = 1'b1, cap_ext = 1'b1, cap_256 = 1'b1;
  logic color16_en, extgfx_en, color256_en, panel_sel, vram_wide;
  logic clk_bit1, clk_bit2, fast_clk, fast_clk_chg, analog_pal;
  logic attr4_gfx, col40, hide_odd, disp_en;

  always #2 clk = ~clk;

  disp_mode_cmd_dec #(.CMD_W(CMD_W)) dut_i (.*);

  typedef struct {
    logic [13:0] v;
    string       tag;
  } exp_t;
  exp_t q[$];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Independent model state
  bit m_c16, m_unl, m_ext, m_c256, m_panel, m_wide, m_b1, m_b2, m_pf, m_chg;
  bit m_attr, m_col40, m_hide, m_disp;

  function automatic logic [13:0] snap_model();
    bit f;
    f = m_b1 && m_b2;
    return {m_c16, m_ext, m_c256, m_panel, m_wide, m_b1, m_b2, f, m_chg,
            (m_c16 || m_c256), m_attr, m_col40, m_hide, m_disp};
  endfunction

  function automatic bit known_mode(int b);
    return b inside {8'h00, 8'h01, 8'h04, 8'h05, 8'h06, 8'h07, 8'h20, 8'h21,
                     8'h40, 8'h41, 8'h68, 8'h69, 8'h82, 8'h83, 8'h84, 8'h85};
  endfunction

  function automatic bit known_ras(int b);
    return b inside {8'h00, 8'h01, 8'h04, 8'h05, 8'h08, 8'h09, 8'h0E, 8'h0F};
  endfunction

  task automatic model_mode(input logic [7:0] b);
    case (b)
      8'h00: m_c16 = 0;
      8'h01: if (cap_16c) m_c16 = 1;
      8'h06: m_unl = 0;
      8'h07: m_unl = 1;
      8'h04: if (m_unl) m_ext = 0;
      8'h05: if (m_unl && cap_ext) m_ext = 1;
      8'h20: if (m_unl && cap_ext) m_c256 = 0;
      8'h21: if (m_unl && cap_ext && cap_256) m_c256 = 1;
      8'h40: m_panel = 0;
      8'h41: m_panel = 1;
      8'h68: m_wide = 0;
      8'h69: m_wide = 1;
      8'h82: m_b1 = 0;
      8'h83: m_b1 = 1;
      8'h84: m_b2 = 0;
      8'h85: m_b2 = 1;
      default: ;
    endcase
  endtask

  task automatic model_ras(input logic [7:0] b);
    case (b)
      8'h00: m_attr = 0;
      8'h01: m_attr = 1;
      8'h04: m_col40 = 0;
      8'h05: m_col40 = 1;
      8'h08: m_hide = 0;
      8'h09: m_hide = 1;
      8'h0E: m_disp = 0;
      8'h0F: m_disp = 1;
      default: ;
    endcase
  endtask

  task automatic push_exp(input string tag);
    bit f;
    exp_t e;
    f = m_b1 && m_b2;
    m_chg = (f != m_pf);
    m_pf = f;
    e.v = snap_model();
    e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: one command per cycle, expected state pushed after the edge
  task automatic send_mode(input logic [7:0] b, input string tag);
    @(negedge clk);
    mode_vld = 1'b1;
    mode_cmd = b;
    model_mode(b);
    @(posedge clk);
    #1;
    mode_vld = 1'b0;
    push_exp(tag);
  endtask

  task automatic send_ras(input logic [7:0] b, input string tag);
    @(negedge clk);
    ras_vld = 1'b1;
    ras_cmd = b;
    model_ras(b);
    @(posedge clk);
    #1;
    ras_vld = 1'b0;
    push_exp(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    @(posedge clk);
    #1;
    push_exp(tag);
  endtask

  // Monitor: compares at the falling edge after each result
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [13:0] got;
      e = q.pop_front();
      got = {color16_en, extgfx_en, color256_en, panel_sel, vram_wide, clk_bit1,
             clk_bit2, fast_clk, fast_clk_chg, analog_pal, attr4_gfx, col40,
             hide_odd, disp_en};
      total++;
      if (got !== e.v) begin
        bad++;
        $display("FAIL %s got=%b exp=%b", e.tag, got, e.v);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    push_exp("R1 reset state");
    idle("R1 reset state held");

    // R2: 16-color enable and its strap
    send_mode(8'h01, "R2 set c16");
    send_mode(8'h00, "R2 clear c16");
    cap_16c = 1'b0;
    send_mode(8'h01, "R2 set ignored strap low");
    cap_16c = 1'b1;
    send_mode(8'h01, "R2 set again");

    // R3: unlock latch and extended graphics
    send_mode(8'h05, "R3 ext set while locked");
    send_mode(8'h07, "R3 unlock");
    cap_ext = 1'b0;
    send_mode(8'h05, "R3 ext set without strap");
    cap_ext = 1'b1;
    send_mode(8'h05, "R3 ext set unlocked");
    send_mode(8'h04, "R3 ext clear unlocked");
    send_mode(8'h05, "R3 ext set again");
    send_mode(8'h06, "R3 lock");
    send_mode(8'h04, "R3 ext clear while locked");

    // R4: 256-color enable
    send_mode(8'h21, "R4 c256 set while locked");
    send_mode(8'h07, "R4 unlock");
    cap_256 = 1'b0;
    send_mode(8'h21, "R4 c256 set without 256 strap");
    cap_256 = 1'b1;
    send_mode(8'h21, "R4 c256 set");
    send_mode(8'h00, "R8 analog held by c256");
    cap_ext = 1'b0;
    send_mode(8'h20, "R4 c256 clear without ext strap");
    cap_ext = 1'b1;
    send_mode(8'h20, "R4 c256 clear");
    send_mode(8'h01, "R8 analog from c16");

    // R5: display type and boundary
    send_mode(8'h41, "R5 panel");
    send_mode(8'h69, "R5 wide");
    send_mode(8'h40, "R5 crt");
    send_mode(8'h68, "R5 narrow");

    // R6, R7: clock bits and change pulse
    send_mode(8'h83, "R6 bit1 only");
    idle("R7 no pulse");
    send_mode(8'h85, "R6 R7 both bits rise");
    idle("R7 pulse drops");
    send_mode(8'h85, "R7 rewrite no pulse");
    send_mode(8'h84, "R6 R7 bit2 clear fall");
    send_mode(8'h85, "R7 back to back rise");
    send_mode(8'h82, "R7 back to back fall");
    send_mode(8'h83, "R11 restore bit1");

    // R9: raster port
    send_ras(8'h01, "R9 attr set");
    send_ras(8'h05, "R9 col40 set");
    send_ras(8'h09, "R9 hide set");
    send_ras(8'h0F, "R9 disp set");
    send_ras(8'h04, "R9 col40 clear");
    send_ras(8'h00, "R9 attr clear mode port untouched");

    // R10: sweep all unlisted bytes on both ports with mixed state
    send_mode(8'h69, "R10 prep");
    send_mode(8'h05, "R10 prep");
    send_ras(8'h01, "R10 prep");
    for (int i = 0; i < 256; i++) begin
      if (!known_mode(i)) send_mode(8'(i), "R10 mode unknown");
    end
    for (int i = 0; i < 256; i++) begin
      if (!known_ras(i)) send_ras(8'(i), "R10 raster unknown");
    end

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule